// File: doc/BRIEF.md
# Scan Chain Test Controller

This block holds a register bank in front of a small combinational logic block under test. Each bank bit has a 2:1 mux on its input. In test mode the mux takes the previous bit, and all bits then form one serial shift register. In normal mode the mux takes the logic's next-state output. A controller drives the mux select and runs the test one pattern at a time: it shifts the pattern in, clocks the bank once in normal mode to capture the logic's response, and shifts that response out. The response of one pattern is shifted out during the same N clocks that load the next pattern.

A host starts a run with a pattern count. The controller publishes the index of the pattern it needs next. The host answers with that stimulus word and its expected response word in parallel. The controller serializes the stimulus LSB first and compares each response bit as it leaves the chain. It reports a sticky fail flag and the index of the first failing pattern. After the last pattern, one extra shift phase with zero fill unloads the final response.

Top module: `scan_test_ctrl`

## Requirements
- R1: In a shift cycle every bank bit i takes bit i+1, and the top bit takes scan-in. Stimulus bit j is sent in shift cycle j, so after N shifts chain bit j holds stimulus bit j. Chain bit 0 is scan_out_o, so captured response bit j appears on scan_out_o in the j-th cycle of the following shift phase.
- R2: Every shift phase lasts exactly N clocks. A run of P patterns (1 <= P) takes 1 + P*(N+1) + N clocks from the edge that accepts start_i to the first edge where done_o is high.
- R3: Each pattern gets exactly one capture cycle. In that cycle bank bit i loads q[(i+1) mod N] XOR (q[i] AND q[(i-1) mod N]).
- R4: The response of pattern k is compared while pattern k+1 is being loaded. Bits shifted out in the first shift phase of a run are never compared.
- R5: After the last capture, one shift phase feeds zeros into the chain and compares the last response. When done_o rises, the chain holds all zeros, so scan_out_o stays low for the whole first shift phase of the next run.
- R6: fail_o is sticky for the rest of a run. fail_idx_o holds the index of the first pattern with any mismatching bit and is not changed by later mismatches. Both are cleared only when a new run starts.
- R7: When every expected word equals the logic's true response, the run ends with fail_o low.
- R8: A pattern count of 0 moves straight to done one clock after start, with fail_o low. A count above MAX_PAT is treated as MAX_PAT.
- R9: start_i is ignored while busy_o is high, and the run in progress keeps its length and its result. After reset, busy_o, done_o, fail_o and scan_en_o are low and pat_idx_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a run when idle or done |
| num_pat_i | input | $clog2(MAX_PAT+1) | Pattern count, sampled at start |
| pat_i | input | N | Stimulus word for pattern pat_idx_o |
| exp_i | input | N | Expected response word for pattern pat_idx_o |
| pat_idx_o | output | $clog2(MAX_PAT) | Index of the pattern the host must present |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run finished, results valid |
| fail_o | output | 1 | Sticky mismatch flag |
| fail_idx_o | output | $clog2(MAX_PAT) | Index of first failing pattern |
| scan_en_o | output | 1 | Bank in shift mode |
| scan_out_o | output | 1 | Serial chain output (bank bit 0) |

## Verification
The bench counts clock edges from the edge that accepts start_i. Values seen after edge c are read at the following falling edge. Pre-test chain bits appear on scan_out_o after edges 1 to N, and the first pattern's response bits appear after edges N+2 to 2N+1. done_o is due after edge 1+P*(N+1)+N, or after edge 1 for a zero count. fail_o and fail_idx_o are read once done_o is high and compared with a reference model of the logic and the first corrupted index. Every check samples at its computed edge and never waits open-endedly for a level.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_CAPTURE,
    ST_UNLOAD,
    ST_DONE
  } scan_state_e;
endpackage

// File: rtl/scan_cut_logic.sv
module scan_cut_logic #(
  parameter int N = 8
) (
  input  logic [N-1:0] q_i,
  output logic [N-1:0] d_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign d_o[i] = q_i[(i+1)%N] ^ (q_i[i] & q_i[(i+N-1)%N]);
  end
endmodule

// File: rtl/scan_reg_bank.sv
module scan_reg_bank #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         scan_en_i,
  input  logic         cap_en_i,
  input  logic         scan_in_i,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o,
  output logic         scan_out_o
);
  logic [N-1:0] q_q;
  logic [N-1:0] nxt;
  logic         upd;

  assign upd = scan_en_i | cap_en_i;

  for (genvar i = 0; i < N; i++) begin : g_cell
    logic chain_src;
    if (i == N-1) begin : g_top
      assign chain_src = scan_in_i;
    end else begin : g_mid
      assign chain_src = q_q[i+1];
    end
    assign nxt[i] = scan_en_i ? chain_src : d_i[i];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  q_q[i] <= 1'b0;
      else if (upd) q_q[i] <= nxt[i];
    end
  end

  assign q_o        = q_q;
  assign scan_out_o = q_q[0];

  a_r1_shift_moves: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_en_i |=> (q_q[N-2:0] == $past(q_q[N-1:1])) && (q_q[N-1] == $past(scan_in_i)));

  a_r3_capture_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_en_i && !scan_en_i) |=> q_q == $past(d_i));

  a_r3_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cap_en_i && !scan_en_i) |=> $stable(q_q));
endmodule

// File: rtl/scan_seq_ctrl.sv
module scan_seq_ctrl
  import scan_pkg::*;
#(
  parameter int N       = 8,
  parameter int MAX_PAT = 16,
  localparam int IDX_W  = $clog2(MAX_PAT),
  localparam int CNT_W  = $clog2(MAX_PAT+1),
  localparam int BIT_W  = (N > 2) ? $clog2(N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] num_pat_i,
  input  logic [N-1:0]     pat_i,
  input  logic [N-1:0]     exp_i,
  input  logic             scan_bit_i,
  output logic             scan_en_o,
  output logic             cap_en_o,
  output logic             scan_in_o,
  output logic [IDX_W-1:0] pat_idx_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             fail_o,
  output logic [IDX_W-1:0] fail_idx_o
);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(N-1);

  scan_state_e      state_q;
  logic [BIT_W-1:0] bit_cnt_q;
  logic [IDX_W-1:0] pat_cnt_q, last_idx_q, fail_idx_q;
  logic [N-1:0]     pat_sr_q, exp_sr_q, exp_nxt_q;
  logic             fail_q;

  logic [CNT_W-1:0] num_eff;
  logic             shifting, cmp_active, mismatch, phase_end;
  logic [IDX_W-1:0] cmp_idx;

  assign num_eff    = (num_pat_i > CNT_W'(MAX_PAT)) ? CNT_W'(MAX_PAT) : num_pat_i;
  assign shifting   = (state_q == ST_SHIFT) || (state_q == ST_UNLOAD);
  assign phase_end  = shifting && (bit_cnt_q == LAST_BIT);
  // first shift phase of a run unloads stale chain contents
  assign cmp_active = ((state_q == ST_SHIFT) && (pat_cnt_q != '0)) || (state_q == ST_UNLOAD);
  assign cmp_idx    = (state_q == ST_UNLOAD) ? pat_cnt_q : pat_cnt_q - 1'b1;
  assign mismatch   = cmp_active && (scan_bit_i != exp_sr_q[0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      bit_cnt_q  <= '0;
      pat_cnt_q  <= '0;
      last_idx_q <= '0;
      pat_sr_q   <= '0;
      exp_sr_q   <= '0;
      exp_nxt_q  <= '0;
      fail_q     <= 1'b0;
      fail_idx_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_DONE: begin
          if (start_i) begin
            fail_q     <= 1'b0;
            fail_idx_q <= '0;
            bit_cnt_q  <= '0;
            pat_cnt_q  <= '0;
            if (num_eff == '0) begin
              state_q <= ST_DONE;
            end else begin
              last_idx_q <= IDX_W'(num_eff - 1'b1);
              pat_sr_q   <= pat_i;
              exp_nxt_q  <= exp_i;
              state_q    <= ST_SHIFT;
            end
          end
        end
        ST_SHIFT, ST_UNLOAD: begin
          pat_sr_q  <= {1'b0, pat_sr_q[N-1:1]};
          exp_sr_q  <= {1'b0, exp_sr_q[N-1:1]};
          bit_cnt_q <= bit_cnt_q + 1'b1;
          if (mismatch && !fail_q) begin
            fail_q     <= 1'b1;
            fail_idx_q <= cmp_idx;
          end
          if (phase_end) begin
            bit_cnt_q <= '0;
            if (state_q == ST_SHIFT) begin
              state_q <= ST_CAPTURE;
            end else begin
              pat_cnt_q <= '0;
              state_q   <= ST_DONE;
            end
          end
        end
        ST_CAPTURE: begin
          exp_sr_q <= exp_nxt_q;
          if (pat_cnt_q == last_idx_q) begin
            pat_sr_q <= '0;
            state_q  <= ST_UNLOAD;
          end else begin
            pat_cnt_q <= pat_cnt_q + 1'b1;
            pat_sr_q  <= pat_i;
            exp_nxt_q <= exp_i;
            state_q   <= ST_SHIFT;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign scan_en_o  = shifting;
  assign cap_en_o   = (state_q == ST_CAPTURE);
  assign scan_in_o  = pat_sr_q[0];
  assign pat_idx_o  = (state_q == ST_CAPTURE) ? pat_cnt_q + 1'b1 : pat_cnt_q;
  assign busy_o     = (state_q != ST_IDLE) && (state_q != ST_DONE);
  assign done_o     = (state_q == ST_DONE);
  assign fail_o     = fail_q;
  assign fail_idx_o = fail_idx_q;

  a_r3_single_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CAPTURE) |=> (state_q != ST_CAPTURE));

  a_r2_phase_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shifting && bit_cnt_q != LAST_BIT) |=> (state_q == $past(state_q)));

  a_r2_phase_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_end |=> !shifting);

  a_r6_fail_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_q && busy_o) |=> fail_q);

  a_r6_first_idx_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_q && busy_o) |=> $stable(fail_idx_q));

  a_r5_unload_zero_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_UNLOAD) |-> !scan_in_o);
endmodule

// File: rtl/scan_test_ctrl.sv
module scan_test_ctrl #(
  parameter int N       = 8,
  parameter int MAX_PAT = 16,
  localparam int IDX_W  = $clog2(MAX_PAT),
  localparam int CNT_W  = $clog2(MAX_PAT+1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] num_pat_i,
  input  logic [N-1:0]     pat_i,
  input  logic [N-1:0]     exp_i,
  output logic [IDX_W-1:0] pat_idx_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             fail_o,
  output logic [IDX_W-1:0] fail_idx_o,
  output logic             scan_en_o,
  output logic             scan_out_o
);
  logic [N-1:0] bank_q, cut_d;
  logic         scan_en, cap_en, scan_in;

  scan_seq_ctrl #(.N(N), .MAX_PAT(MAX_PAT)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .num_pat_i  (num_pat_i),
    .pat_i      (pat_i),
    .exp_i      (exp_i),
    .scan_bit_i (scan_out_o),
    .scan_en_o  (scan_en),
    .cap_en_o   (cap_en),
    .scan_in_o  (scan_in),
    .pat_idx_o  (pat_idx_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .fail_o     (fail_o),
    .fail_idx_o (fail_idx_o)
  );

  scan_reg_bank #(.N(N)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scan_en_i  (scan_en),
    .cap_en_i   (cap_en),
    .scan_in_i  (scan_in),
    .d_i        (cut_d),
    .q_o        (bank_q),
    .scan_out_o (scan_out_o)
  );

  scan_cut_logic #(.N(N)) u_cut (
    .q_i (bank_q),
    .d_o (cut_d)
  );

  assign scan_en_o = scan_en;

  a_r9_modes_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(scan_en && cap_en));
endmodule

// File: tb/scan_test_ctrl_test.sv
module scan_test_ctrl_test;
  localparam int N       = 8;
  localparam int MAX_PAT = 16;
  localparam int IDX_W   = $clog2(MAX_PAT);
  localparam int CNT_W   = $clog2(MAX_PAT+1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [CNT_W-1:0] num_pat = '0;
  logic [N-1:0]     pat_w, exp_w;
  logic [IDX_W-1:0] pat_idx, fail_idx;
  logic             busy, done, fail, scan_en, scan_out;

  logic [N-1:0] pats [MAX_PAT];
  logic [N-1:0] exps [MAX_PAT];

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  assign pat_w = pats[pat_idx];
  assign exp_w = exps[pat_idx];

  scan_test_ctrl #(.N(N), .MAX_PAT(MAX_PAT)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .num_pat_i(num_pat),
    .pat_i(pat_w), .exp_i(exp_w), .pat_idx_o(pat_idx), .busy_o(busy),
    .done_o(done), .fail_o(fail), .fail_idx_o(fail_idx),
    .scan_en_o(scan_en), .scan_out_o(scan_out)
  );

  function automatic logic [N-1:0] cut_ref(input logic [N-1:0] q);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = q[(i+1)%N] ^ (q[i] & q[(i+N-1)%N]);
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic summary_finish();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary_finish();
  end

  // fills host tables; corrupt bit per pattern: -1 = none
  task automatic load_set(input int p, input int bad_a, input int bad_b);
    for (int k = 0; k < MAX_PAT; k++) begin
      pats[k] = N'($urandom);
      exps[k] = cut_ref(pats[k]);
    end
    if (bad_a >= 0) exps[bad_a] ^= N'(1) << ($urandom % N);
    if (bad_b >= 0) exps[bad_b] ^= N'(1) << ($urandom % N);
    if (p < 0) $display("bad count");
  endtask

  task automatic run(input int p, input int eff, input bit poke, input int exp_fidx);
    int c;
    logic [N-1:0] w0, w1;
    bit exp_fail;
    c = 0; w0 = '0; w1 = '0;
    exp_fail = (exp_fidx >= 0);
    @(negedge clk);
    num_pat = CNT_W'(p);
    start = 1'b1;
    forever begin
      @(posedge clk);
      c++;
      @(negedge clk);
      if (c == 1) start = 1'b0;
      if (poke && c == 4) begin start = 1'b1; num_pat = CNT_W'(1); end
      if (poke && c == 5) start = 1'b0;
      if (c >= 1 && c <= N) w0[c-1] = scan_out;
      if (c >= N+2 && c <= 2*N+1) w1[c-N-2] = scan_out;
      if (done || c > 2000) break;
    end
    if (eff == 0) begin
      chk(c == 1, "R8 zero count done cycle", c, 1);
    end else begin
      chk(c == 1 + eff*(N+1) + N, "R2 run length", c, 1 + eff*(N+1) + N);
      chk(w0 == '0, "R5 zero fill seen in next first phase", int'(w0), 0);
      chk(w1 == cut_ref(pats[0]), "R1 R3 response order on scan_out", int'(w1), int'(cut_ref(pats[0])));
    end
    chk(fail == exp_fail, "R6 R7 fail flag", int'(fail), int'(exp_fail));
    if (exp_fail)
      chk(int'(fail_idx) == exp_fidx, "R6 first failing index", int'(fail_idx), exp_fidx);
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < MAX_PAT; k++) begin pats[k] = '0; exps[k] = '0; end
    #23;
    @(negedge clk);
    chk(!busy && !done && !fail && !scan_en, "R9 reset outputs", int'({busy, done, fail, scan_en}), 0);
    chk(pat_idx == '0, "R9 reset pattern index", int'(pat_idx), 0);
    rst_n = 1'b1;

    // R7: all expectations correct
    load_set(4, -1, -1);
    run(4, 4, 1'b0, -1);

    // R4 R5: single pattern, compared only in the final unload
    load_set(1, 0, -1);
    run(1, 1, 1'b0, 0);

    // R6: two corruptions, first one reported
    load_set(5, 2, 4);
    run(5, 5, 1'b0, 2);

    // R5: last of a full set is corrupted
    load_set(MAX_PAT, MAX_PAT-1, -1);
    run(MAX_PAT, MAX_PAT, 1'b0, MAX_PAT-1);

    // R8: zero count after a failing run clears fail
    run(0, 0, 1'b0, -1);

    // R8: count above limit clamps
    load_set(MAX_PAT, -1, -1);
    run(MAX_PAT+5, MAX_PAT, 1'b0, -1);

    // R9: start while busy has no effect
    load_set(3, 1, -1);
    run(3, 3, 1'b1, 1);

    // R4: first phase never compared: first pattern wrong only in its
    // own stimulus slot would be caught in phase two, so corrupt none
    load_set(2, -1, -1);
    run(2, 2, 1'b0, -1);

    for (int r = 0; r < 8; r++) begin
      int p, bad;
      p = 1 + int'($urandom % MAX_PAT);
      bad = (($urandom % 3) == 0) ? int'($urandom % p) : -1;
      load_set(p, bad, -1);
      run(p, p, 1'b0, bad);
    end

    summary_finish();
  end
endmodule